// File: doc/BRIEF.md
# Boot Stream Instruction Packer

This block sits behind the receive side of a serial boot port. The host delivers its boot image as a stream of subwords. A subword is a byte, a half-word or a full 32-bit word, depending on the host width chosen by `mode_i`. Each subword arrives with a one-cycle valid strobe. The block collects the subwords into a 32-bit receive word, placing the earliest subword at the least significant end. It flags each finished word on `word_done_o`.

Finished words are handled in groups of three. Each group of three 32-bit words is regrouped into two 48-bit program instructions. The first instruction holds the whole first word in its low 32 bits and the low half of the second word in its high 16 bits. The second instruction holds the high half of the second word in its low 16 bits and the whole third word in its high 32 bits. Each instruction leaves the block with a one-cycle write strobe. The instructions go to consecutive memory addresses, counting up from a base address that is captured while reset is asserted.

The host width is also captured only during reset. A mode change in the middle of a stream therefore cannot break a partly packed word.

Top module: `boot_insn_packer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `wr_en_o` and `word_done_o` are 0 and `wr_addr_o` equals the `base_addr_i` value captured during reset.
- R2: The `mode_i` encoding is 0 for an 8-bit host, 1 for a 16-bit host, and 2 or 3 for a 32-bit host. One 32-bit word is complete after 4, 2 or 1 accepted subwords respectively. `word_done_o` is high for one cycle, in the cycle after the clock edge that accepts the final subword, and `word_o` holds the word during that cycle.
- R3: Subwords are placed lowest first. The k-th byte (k = 0..3) goes to bits [8k+7:8k], and the k-th half-word (k = 0..1) goes to bits [16k+15:16k]. In narrow modes only `sub_data_i[7:0]` or `sub_data_i[15:0]` is used.
- R4: For the words W0, W1 and W2 of a group, the first instruction is `{W1[15:0], W0[31:0]}`.
- R5: The second instruction of a group is `{W2[31:0], W1[31:16]}`.
- R6: `wr_en_o` is high for exactly one cycle, in the cycle after `word_done_o` reports W1 and in the cycle after it reports W2. It is never raised for W0.
- R7: The first instruction after reset is written at the base address. Each later write uses the previous write address plus one, and the address does not change between writes.
- R8: A change of `mode_i` while `rst` is low has no effect on packing until the next reset.
- R9: Cycles in which `sub_valid_i` is low leave the packing state unchanged. Gaps between subwords do not alter the words or the instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures mode and base |
| mode_i | input | 2 | Host width: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| base_addr_i | input | ADDR_W (20) | First instruction address, sampled during reset |
| sub_valid_i | input | 1 | Subword valid strobe |
| sub_data_i | input | WORD_W (32) | Subword, right-aligned |
| word_done_o | output | 1 | One-cycle pulse: a 32-bit word is complete |
| word_o | output | WORD_W (32) | Completed 32-bit word, valid with `word_done_o` |
| wr_en_o | output | 1 | One-cycle instruction write strobe |
| wr_addr_o | output | ADDR_W (20) | Instruction write address |
| wr_data_o | output | INSN_W (48) | 48-bit instruction |

## Verification
A subword accepted at one edge produces `word_done_o` one cycle later. When that word is W1 or W2 of a group, `wr_en_o` follows one cycle after that, so an instruction appears two cycles after the final subword of its second or third word. The bench drives inputs on the falling edge and samples on the following falling edges. In the 32-bit latency scenario it checks the outputs at each falling edge against these exact offsets. In the other scenarios a falling-edge monitor logs every word pulse and every write, and the logs are then compared with the expected words, instructions and addresses.

// File: rtl/boot_pack_pkg.sv
package boot_pack_pkg;

   typedef enum logic [1:0] {
      HOST_W8  = 2'd0,
      HOST_W16 = 2'd1,
      HOST_W32 = 2'd2,
      HOST_WX  = 2'd3
   } host_width_e;

   typedef enum logic [1:0] {
      GRP_FIRST  = 2'd0,
      GRP_SECOND = 2'd1,
      GRP_THIRD  = 2'd2
   } grp_phase_e;

endpackage

// File: rtl/subword_assembler.sv
module subword_assembler
   import boot_pack_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode_i,
   input  logic              sub_valid_i,
   input  logic [WORD_W-1:0] sub_data_i,
   output logic              word_done_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int LANES = WORD_W / 8;
   localparam int PW    = $clog2(LANES);

   if (WORD_W != 32) begin : g_bad_width
      $error("subword_assembler: WORD_W must be 32");
   end

   host_width_e      mode_q;
   logic [PW-1:0]    pos_q;
   logic [PW:0]      step;
   logic [PW:0]      pos_next;
   logic             last_sub;
   logic             done_q;
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst) mode_q <= host_width_e'(mode_i);
   end

   always_comb begin
      unique case (mode_q)
         HOST_W8:  step = (PW+1)'(1);
         HOST_W16: step = (PW+1)'(2);
         default:  step = (PW+1)'(LANES);
      endcase
      pos_next = {1'b0, pos_q} + step;
      last_sub = (pos_next == (PW+1)'(LANES));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= sub_valid_i && last_sub;
         if (sub_valid_i) pos_q <= pos_next[PW-1:0];
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic       lane_we;
      logic [7:0] lane_byte;
      always_comb begin
         unique case (mode_q)
            HOST_W8: begin
               lane_we   = (pos_q == PW'(i));
               lane_byte = sub_data_i[7:0];
            end
            HOST_W16: begin
               lane_we   = ((pos_q >> 1) == PW'(i >> 1));
               lane_byte = sub_data_i[8*(i%2) +: 8];
            end
            default: begin
               lane_we   = 1'b1;
               lane_byte = sub_data_i[8*i +: 8];
            end
         endcase
      end
      always_ff @(posedge clk) begin
         if (rst) word_q[8*i +: 8] <= '0;
         else if (sub_valid_i && lane_we) word_q[8*i +: 8] <= lane_byte;
      end
   end

   assign word_done_o = done_q;
   assign word_o      = word_q;

   p_done_after_valid_r2: assert property (@(posedge clk) disable iff (rst)
      done_q |-> $past(sub_valid_i));

   p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(mode_q));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !sub_valid_i |=> ($stable(pos_q) && $stable(word_q)));

endmodule

// File: rtl/insn_regrouper.sv
module insn_regrouper
   import boot_pack_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int INSN_W = 48
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_done_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              wr_en_o,
   output logic [INSN_W-1:0] wr_data_o
);
   localparam int HALF_W = WORD_W / 2;

   if (INSN_W != WORD_W + HALF_W) begin : g_bad_insn
      $error("insn_regrouper: INSN_W must be 1.5 x WORD_W");
   end

   grp_phase_e        phase_q;
   logic [WORD_W-1:0] first_q;
   logic [HALF_W-1:0] upper_q;
   logic              wr_q;
   logic [INSN_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= GRP_FIRST;
         first_q <= '0;
         upper_q <= '0;
         wr_q    <= 1'b0;
         data_q  <= '0;
      end else begin
         wr_q <= 1'b0;
         if (word_done_i) begin
            unique case (phase_q)
               GRP_FIRST: begin
                  first_q <= word_i;
                  phase_q <= GRP_SECOND;
               end
               GRP_SECOND: begin
                  wr_q    <= 1'b1;
                  data_q  <= {word_i[HALF_W-1:0], first_q};
                  upper_q <= word_i[WORD_W-1:HALF_W];
                  phase_q <= GRP_THIRD;
               end
               default: begin
                  wr_q    <= 1'b1;
                  data_q  <= {word_i, upper_q};
                  phase_q <= GRP_FIRST;
               end
            endcase
         end
      end
   end

   assign wr_en_o   = wr_q;
   assign wr_data_o = data_q;

   p_wr_after_word_r6: assert property (@(posedge clk) disable iff (rst)
      wr_q |-> $past(word_done_i));

   p_no_wr_on_first_r6: assert property (@(posedge clk) disable iff (rst)
      wr_q |-> ($past(phase_q) != GRP_FIRST));

   p_phase_legal_r4: assert property (@(posedge clk) disable iff (rst)
      phase_q != grp_phase_e'(2'd3));

endmodule

// File: rtl/insn_addr_gen.sv
module insn_addr_gen #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              wr_en_i,
   output logic [ADDR_W-1:0] addr_o
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("insn_addr_gen: ADDR_W too small");
   end

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (rst)          addr_q <= base_i;
      else if (wr_en_i) addr_q <= addr_q + ADDR_W'(1);
   end

   assign addr_o = addr_q;

   p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
      wr_en_i |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

   p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !wr_en_i |=> $stable(addr_q));

endmodule

// File: rtl/boot_insn_packer.sv
module boot_insn_packer
   import boot_pack_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int INSN_W = 48,
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic              sub_valid_i,
   input  logic [WORD_W-1:0] sub_data_i,
   output logic              word_done_o,
   output logic [WORD_W-1:0] word_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [INSN_W-1:0] wr_data_o
);
   logic              done_w;
   logic [WORD_W-1:0] word_w;
   logic              wr_w;

   subword_assembler #(.WORD_W(WORD_W)) asm_i (
      .clk(clk), .rst(rst), .mode_i(mode_i),
      .sub_valid_i(sub_valid_i), .sub_data_i(sub_data_i),
      .word_done_o(done_w), .word_o(word_w)
   );

   insn_regrouper #(.WORD_W(WORD_W), .INSN_W(INSN_W)) grp_i (
      .clk(clk), .rst(rst),
      .word_done_i(done_w), .word_i(word_w),
      .wr_en_o(wr_w), .wr_data_o(wr_data_o)
   );

   insn_addr_gen #(.ADDR_W(ADDR_W)) adr_i (
      .clk(clk), .rst(rst), .base_i(base_addr_i),
      .wr_en_i(wr_w), .addr_o(wr_addr_o)
   );

   assign word_done_o = done_w;
   assign word_o      = word_w;
   assign wr_en_o     = wr_w;

   p_reset_quiet_r1: assert property (@(posedge clk)
      $past(rst) |-> (!wr_w && !done_w));

endmodule

// File: tb/boot_insn_packer_tb_top.sv
module boot_insn_packer_tb_top;
   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    mode_i = 2'd0;
   logic [AW-1:0] base_addr_i = '0;
   logic          sub_valid_i = 1'b0;
   logic [31:0]   sub_data_i = '0;
   logic          word_done_o;
   logic [31:0]   word_o;
   logic          wr_en_o;
   logic [AW-1:0] wr_addr_o;
   logic [47:0]   wr_data_o;

   int n_chk = 0;
   int n_err = 0;

   logic [31:0]   wlog [0:63];
   logic [47:0]   dlog [0:63];
   logic [AW-1:0] alog [0:63];
   int nw = 0;
   int nd = 0;

   always #4 clk = ~clk;

   boot_insn_packer #(.WORD_W(32), .INSN_W(48), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst(rst), .mode_i(mode_i), .base_addr_i(base_addr_i),
      .sub_valid_i(sub_valid_i), .sub_data_i(sub_data_i),
      .word_done_o(word_done_o), .word_o(word_o),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
   );

   always @(negedge clk) begin
      if (!rst && word_done_o && nw < 64) begin
         wlog[nw] = word_o;
         nw = nw + 1;
      end
      if (!rst && wr_en_o && nd < 64) begin
         dlog[nd] = wr_data_o;
         alog[nd] = wr_addr_o;
         nd = nd + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] m, input logic [AW-1:0] b);
      @(negedge clk);
      rst = 1'b1; mode_i = m; base_addr_i = b; sub_valid_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic put(input logic [31:0] d);
      sub_valid_i = 1'b1; sub_data_i = d;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      sub_valid_i = 1'b0; sub_data_i = 32'hDEAD_BEEF;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_group(input string tag, input int w0, input int d0, input logic [AW-1:0] b);
      chk(nw - w0 == 3, {tag, " R2 word count"}, 64'(nw - w0), 64'd3);
      chk(wlog[w0] == 32'h33445566, {tag, " R3 W0"}, 64'(wlog[w0]), 64'h33445566);
      chk(wlog[w0+1] == 32'hCCDD1122, {tag, " R3 W1"}, 64'(wlog[w0+1]), 64'hCCDD1122);
      chk(wlog[w0+2] == 32'h7788AABB, {tag, " R3 W2"}, 64'(wlog[w0+2]), 64'h7788AABB);
      chk(nd - d0 == 2, {tag, " R6 write count"}, 64'(nd - d0), 64'd2);
      chk(dlog[d0] == 48'h112233445566, {tag, " R4 insn0"}, 64'(dlog[d0]), 64'h112233445566);
      chk(dlog[d0+1] == 48'h7788AABBCCDD, {tag, " R5 insn1"}, 64'(dlog[d0+1]), 64'h7788AABBCCDD);
      chk(alog[d0] == b, {tag, " R7 addr0"}, 64'(alog[d0]), 64'(b));
      chk(alog[d0+1] == b + 1, {tag, " R7 addr1"}, 64'(alog[d0+1]), 64'(b + 1));
   endtask

   task automatic t_reset();
      rst = 1'b1; base_addr_i = 20'h8C000;
      @(negedge clk); @(negedge clk);
      chk(!wr_en_o && !word_done_o, "R1 outputs in reset", {62'd0, wr_en_o, word_done_o}, 64'd0);
      chk(wr_addr_o == 20'h8C000, "R1 base address", 64'(wr_addr_o), 64'h8C000);
      rst = 1'b0;
      @(negedge clk);
      chk(!wr_en_o && !word_done_o, "R1 after release", {62'd0, wr_en_o, word_done_o}, 64'd0);
   endtask

   task automatic t_bytes();
      int w0, d0;
      logic [7:0] seq [12] = '{8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11,
                               8'hDD, 8'hCC, 8'hBB, 8'hAA, 8'h88, 8'h77};
      do_reset(2'd0, 20'h8C000);
      w0 = nw; d0 = nd;
      for (int i = 0; i < 12; i++) put({24'hFFFFFF, seq[i]});
      idle(4);
      check_group("8-bit", w0, d0, 20'h8C000);
   endtask

   task automatic t_halves_gaps();
      int w0, d0;
      logic [15:0] seq [6] = '{16'h5566, 16'h3344, 16'h1122, 16'hCCDD, 16'hAABB, 16'h7788};
      do_reset(2'd1, 20'h00100);
      w0 = nw; d0 = nd;
      for (int i = 0; i < 6; i++) begin
         put({16'hFFFF, seq[i]});
         idle(i % 3);
      end
      idle(4);
      check_group("16-bit gaps R9", w0, d0, 20'h00100);
   endtask

   task automatic t_word32_timing();
      do_reset(2'd2, 20'h00040);
      put(32'h33445566);
      chk(word_done_o && word_o == 32'h33445566, "R2 done one cycle after W0", 64'(word_o), 64'h33445566);
      chk(!wr_en_o, "R6 no write for W0", 64'(wr_en_o), 64'd0);
      put(32'hCCDD1122);
      chk(word_done_o && word_o == 32'hCCDD1122, "R2 done W1", 64'(word_o), 64'hCCDD1122);
      chk(!wr_en_o, "R6 no write yet", 64'(wr_en_o), 64'd0);
      put(32'h7788AABB);
      chk(wr_en_o && wr_data_o == 48'h112233445566, "R4 insn0 timing", 64'(wr_data_o), 64'h112233445566);
      chk(wr_addr_o == 20'h00040, "R7 addr base", 64'(wr_addr_o), 64'h40);
      idle(1);
      chk(wr_en_o && wr_data_o == 48'h7788AABBCCDD, "R5 insn1 timing", 64'(wr_data_o), 64'h7788AABBCCDD);
      chk(wr_addr_o == 20'h00041, "R7 addr base+1", 64'(wr_addr_o), 64'h41);
      chk(!word_done_o, "R2 done single cycle", 64'(word_done_o), 64'd0);
      idle(1);
      chk(!wr_en_o, "R6 strobe single cycle", 64'(wr_en_o), 64'd0);
      chk(wr_addr_o == 20'h00042, "R7 addr hold", 64'(wr_addr_o), 64'h42);
      put(32'h0000_0001); put(32'h0003_0002); put(32'h0000_0004);
      idle(3);
      chk(dlog[nd-2] == 48'h0002_0000_0001, "R4 second group", 64'(dlog[nd-2]), 64'h000200000001);
      chk(dlog[nd-1] == 48'h0000_0004_0003, "R5 second group", 64'(dlog[nd-1]), 64'h000000040003);
      chk(alog[nd-1] == 20'h00043, "R7 second group addr", 64'(alog[nd-1]), 64'h43);
   endtask

   task automatic t_mode_change();
      int w0, d0;
      do_reset(2'd0, 20'h00200);
      w0 = nw; d0 = nd;
      put(32'hFFFF_FF11); put(32'hFFFF_FF22);
      mode_i = 2'd2;
      idle(2);
      chk(nw == w0, "R8 no word after 2 bytes", 64'(nw - w0), 64'd0);
      put(32'hFFFF_FF33); put(32'hFFFF_FF44);
      idle(2);
      chk(nw - w0 == 1, "R8 one word after 4 bytes", 64'(nw - w0), 64'd1);
      chk(wlog[w0] == 32'h44332211, "R8 byte packing kept", 64'(wlog[w0]), 64'h44332211);
      chk(nd == d0, "R8 no write", 64'(nd - d0), 64'd0);
      mode_i = 2'd0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_bytes();
      t_halves_gaps();
      t_word32_timing();
      t_mode_change();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule